// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Word-Granular Dirty Tracking

This block sits between a processor's load/store port and main memory. It holds a small direct-mapped array of lines, each line several words wide, and answers word reads and writes from the processor. The write policy is chosen when the block is elaborated. In write-back mode a store that hits updates only the cached word and marks that single word as modified. A store that misses first brings the line in and then merges into it. When a line holding modified words is displaced, only those words go back to memory. In write-through mode every store reaches memory: a hit also updates the cached copy, and a miss bypasses the cache without allocating a line.

Memory is reached through a line-fill read port and a single-word write port. A fill is started by a one-cycle request carrying the line address. Memory then returns every word of the line in ascending order, one word per beat, after its own access delay. Word writes use a valid/ready handshake. For coherence with I/O, an invalidate request names a line address and drops the cached line if its tag matches, modified words included. A flush request writes out every modified word in the cache and leaves every line invalid, so a device can then read memory safely.

Top module: `wbc_top`

## Requirements
- R1: While reset is held and just after it, cpu_ready, inv_done, flush_done, mem_rd_req and mem_wr_valid are low, and every line is invalid, so the first read of any address starts a line fill.
- R2: A read that hits returns the cached word with cpu_ready high exactly two cycles after cpu_req is first sampled high in idle, with no memory traffic.
- R3: A read miss raises mem_rd_req for exactly one cycle with mem_rd_addr equal to the address with its two word-offset bits removed, accepts four beats as words 0 to 3 of the line, returns the requested word and leaves the whole line cached. Word address layout: bits [1:0] word offset, [5:2] line index, [15:6] tag.
- R4: In write-back mode a store that hits writes no memory word, and a later read of that address returns the stored value.
- R5: In write-back mode a store that misses fetches the line, merges the stored word into it and writes no memory word; the other words of the line read back as memory held them.
- R6: Displacing a line in write-back mode writes to memory only its modified words, at their own addresses, in ascending word order, and all of them before the fill request for the new line.
- R7: In write-through mode a store that hits writes the word to memory and into the cache. No word is ever marked modified, so a later displacement writes nothing.
- R8: In write-through mode a store that misses writes the word to memory only, with no line fill, and a later read of that address misses.
- R9: An invalidate whose line address matches a valid line clears the line and drops its modified words without writing them, so the next read refetches. An invalidate whose tag does not match leaves the cached line in place.
- R10: A flush writes every modified word of every line to memory, then pulses flush_done, and leaves all lines invalid.
- R11: When inv_req and cpu_req are both high in an idle cycle, the invalidate completes (inv_done) before the processor access is started; inv_req also takes priority over flush_req, and flush_req over cpu_req.
- R12: Once mem_wr_valid is high and mem_wr_ready low, mem_wr_valid stays high with mem_wr_addr and mem_wr_data unchanged until the word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Word address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion of the processor access |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| inv_req | input | 1 | Invalidate request, held until inv_done |
| inv_addr | input | 14 | Line address to invalidate (tag and index) |
| inv_done | output | 1 | One-cycle completion of the invalidate |
| flush_req | input | 1 | Flush request, held until flush_done |
| flush_done | output | 1 | One-cycle completion of the flush |
| mem_rd_req | output | 1 | One-cycle line-fill request |
| mem_rd_addr | output | 14 | Line address of the fill |
| mem_rd_valid | input | 1 | Fill beat valid |
| mem_rd_data | input | 32 | Fill beat data, words in ascending order |
| mem_wr_valid | output | 1 | Word write valid |
| mem_wr_addr | output | 16 | Word write address |
| mem_wr_data | output | 32 | Word write data |
| mem_wr_ready | input | 1 | Memory accepts the word write |

## Verification
An invalidate and a processor load can arrive in the same idle cycle and name the same line. The bench first fills a line. It then raises inv_req and cpu_req on the same clock edge, both aimed at that line. It records the cycle in which each completion appears. The check passes when inv_done comes strictly before cpu_ready and the load is served by a fresh line fill, not by the discarded line.

// File: rtl/wbc_pkg.sv
// Package: shared controller state encoding for the data cache controller.
// Assumes: imported by wbc_top only; no other shared types are needed.
package wbc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for invalidate, flush or processor request
        ST_LOOK,    // tag compare for the held processor request
        ST_EVICT,   // writing modified words of the displaced line
        ST_FREQ,    // one-cycle fill request to memory
        ST_FILL,    // receiving fill beats
        ST_THRU,    // write-through / write-around word to memory
        ST_RESP,    // processor completion cycle
        ST_INV,     // invalidate one line
        ST_FLUSH,   // walk all lines, write modified words, clear
        ST_FDONE    // flush completion cycle
    } ctl_state_t;

endpackage

// File: rtl/wbc_dirty_pick.sv
// Module: wbc_dirty_pick
// Finds the lowest-numbered set bit in a line's modified-word mask so that
// only modified words are written out, lowest word first.
// Assumes: WORDS is a power of two and OFF_W = log2(WORDS).
module wbc_dirty_pick #(
    parameter int WORDS = 4,
    parameter int OFF_W = 2
) (
    input  logic [WORDS-1:0] mask,
    output logic             any,
    output logic [OFF_W-1:0] first
);

    // Priority select: scanning downward leaves the lowest set bit last.
    always_comb begin
        any   = |mask;
        first = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (mask[i]) first = OFF_W'(i);
        end
    end

endmodule

// File: rtl/wbc_store.sv
// Module: wbc_store
// Holds tags, valid bits, per-word modified bits and line data of a
// direct-mapped cache. One combinational lookup port, plus separate
// command ports for data write, modified-bit set/clear, line install and
// line kill.
// Assumes: the controller never issues conflicting commands to the same
// bit in one cycle; valid and modified bits reset, tags and data do not.
module wbc_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 10,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [OFF_W-1:0]  lk_off,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_valid,
    output logic [WORDS-1:0]  lk_dirty,
    output logic [DATA_W-1:0] lk_word,
    // data word write
    input  logic              dw_en,
    input  logic [IDX_W-1:0]  dw_idx,
    input  logic [OFF_W-1:0]  dw_off,
    input  logic [DATA_W-1:0] dw_data,
    // modified bit set
    input  logic              ds_en,
    input  logic [IDX_W-1:0]  ds_idx,
    input  logic [OFF_W-1:0]  ds_off,
    // modified bit clear
    input  logic              dc_en,
    input  logic [IDX_W-1:0]  dc_idx,
    input  logic [OFF_W-1:0]  dc_off,
    // line install
    input  logic              tv_en,
    input  logic [IDX_W-1:0]  tv_idx,
    input  logic [TAG_W-1:0]  tv_tag,
    // line kill (valid and all modified bits cleared)
    input  logic              kill_en,
    input  logic [IDX_W-1:0]  kill_idx
);

    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [LINES-1:0]  valid_q;
    logic [WORDS-1:0]  dirty_q [LINES];
    logic [DATA_W-1:0] data_q  [LINES][WORDS];

    // Lookup port reads the addressed line combinationally.
    always_comb begin
        lk_tag   = tag_q[lk_idx];
        lk_valid = valid_q[lk_idx];
        lk_dirty = dirty_q[lk_idx];
        lk_word  = data_q[lk_idx][lk_off];
    end

    // Valid and modified state, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int l = 0; l < LINES; l++) dirty_q[l] <= '0;
        end else begin
            if (tv_en) valid_q[tv_idx] <= 1'b1;
            if (ds_en) dirty_q[ds_idx][ds_off] <= 1'b1;
            if (dc_en) dirty_q[dc_idx][dc_off] <= 1'b0;
            if (kill_en) begin
                valid_q[kill_idx] <= 1'b0;
                dirty_q[kill_idx] <= '0;
            end
        end
    end

    // Tag storage, written when a line is installed.
    always_ff @(posedge clk) begin
        if (tv_en) tag_q[tv_idx] <= tv_tag;
    end

    // Data storage, one word per cycle.
    always_ff @(posedge clk) begin
        if (dw_en) data_q[dw_idx][dw_off] <= dw_data;
    end

    // A line never holds modified words while invalid (kill clears both).
    for (genvar g = 0; g < LINES; g++) begin : g_line_chk
        a_r9_dirty_needs_valid: assert property (
            @(posedge clk) disable iff (!rst_n)
            (|dirty_q[g]) |-> valid_q[g]);
    end

endmodule

// File: rtl/wbc_top.sv
// Module: wbc_top
// Direct-mapped data cache controller. WRITE_BACK=1: store hits stay in the
// cache and mark the written word modified; store misses allocate; a
// displaced line writes back only its modified words. WRITE_BACK=0: stores
// always reach memory; store misses do not allocate. Also serves line
// invalidate and whole-cache flush requests.
// Assumes: requesters hold their request until the matching done/ready
// pulse; memory returns fill beats in ascending word order after a
// one-cycle mem_rd_req; word addresses throughout.
module wbc_top #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int WORDS      = 4,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic                        cpu_ready,
    output logic [DATA_W-1:0]           cpu_rdata,
    input  logic                        inv_req,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] inv_addr,
    output logic                        inv_done,
    input  logic                        flush_req,
    output logic                        flush_done,
    output logic                        mem_rd_req,
    output logic [ADDR_W-$clog2(WORDS)-1:0] mem_rd_addr,
    input  logic                        mem_rd_valid,
    input  logic [DATA_W-1:0]           mem_rd_data,
    output logic                        mem_wr_valid,
    output logic [ADDR_W-1:0]           mem_wr_addr,
    output logic [DATA_W-1:0]           mem_wr_data,
    input  logic                        mem_wr_ready
);

    import wbc_pkg::*;

    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    ctl_state_t        state_q, state_d;
    logic [IDX_W-1:0]  fl_idx_q;
    logic [OFF_W-1:0]  fcnt_q;
    logic [DATA_W-1:0] rdata_q;

    // address fields of the held requests
    logic [TAG_W-1:0]  req_tag, inv_tag;
    logic [IDX_W-1:0]  req_idx, inv_idx;
    logic [OFF_W-1:0]  req_off;

    // store interface
    logic [IDX_W-1:0]  lk_idx;
    logic [OFF_W-1:0]  lk_off;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_valid;
    logic [WORDS-1:0]  lk_dirty;
    logic [DATA_W-1:0] lk_word;
    logic              dw_en, ds_en, dc_en, tv_en, kill_en;
    logic [OFF_W-1:0]  dw_off;
    logic [DATA_W-1:0] dw_data;

    logic              any_dirty;
    logic [OFF_W-1:0]  pick;
    logic              hit, fill_last, merge_here;
    ctl_state_t        miss_nxt;

    // Split the request and invalidate addresses into their fields.
    always_comb begin
        req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
        req_idx = cpu_addr[OFF_W +: IDX_W];
        req_off = cpu_addr[OFF_W-1:0];
        inv_tag = inv_addr[IDX_W +: TAG_W];
        inv_idx = inv_addr[IDX_W-1:0];
    end

    // Choose which line and word the lookup port addresses in each state.
    always_comb begin
        case (state_q)
            ST_INV:   lk_idx = inv_idx;
            ST_FLUSH: lk_idx = fl_idx_q;
            default:  lk_idx = req_idx;
        endcase
        lk_off = (state_q == ST_EVICT || state_q == ST_FLUSH) ? pick : req_off;
    end

    wbc_store #(
        .LINES (LINES), .WORDS (WORDS), .DATA_W (DATA_W),
        .TAG_W (TAG_W), .IDX_W (IDX_W), .OFF_W (OFF_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_idx),
        .lk_off   (lk_off),
        .lk_tag   (lk_tag),
        .lk_valid (lk_valid),
        .lk_dirty (lk_dirty),
        .lk_word  (lk_word),
        .dw_en    (dw_en),
        .dw_idx   (req_idx),
        .dw_off   (dw_off),
        .dw_data  (dw_data),
        .ds_en    (ds_en),
        .ds_idx   (req_idx),
        .ds_off   (req_off),
        .dc_en    (dc_en),
        .dc_idx   (lk_idx),
        .dc_off   (pick),
        .tv_en    (tv_en),
        .tv_idx   (req_idx),
        .tv_tag   (req_tag),
        .kill_en  (kill_en),
        .kill_idx (lk_idx)
    );

    wbc_dirty_pick #(.WORDS (WORDS), .OFF_W (OFF_W)) u_pick (
        .mask  (lk_dirty),
        .any   (any_dirty),
        .first (pick)
    );

    // Hit test, fill progress and merge position for the held request.
    always_comb begin
        hit        = lk_valid && (lk_tag == req_tag);
        fill_last  = (fcnt_q == OFF_W'(WORDS - 1));
        merge_here = cpu_we && (fcnt_q == req_off);
        miss_nxt   = (lk_valid && any_dirty) ? ST_EVICT : ST_FREQ;
    end

    // Next-state and command decode of the controller.
    always_comb begin
        state_d      = state_q;
        dw_en        = 1'b0;
        ds_en        = 1'b0;
        dc_en        = 1'b0;
        tv_en        = 1'b0;
        kill_en      = 1'b0;
        cpu_ready    = 1'b0;
        inv_done     = 1'b0;
        flush_done   = 1'b0;
        mem_rd_req   = 1'b0;
        mem_wr_valid = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (inv_req)        state_d = ST_INV;
                else if (flush_req) state_d = ST_FLUSH;
                else if (cpu_req)   state_d = ST_LOOK;
            end
            ST_LOOK: begin
                if (!cpu_we) begin
                    state_d = hit ? ST_RESP : miss_nxt;
                end else if (WRITE_BACK) begin
                    if (hit) begin
                        dw_en   = 1'b1;
                        ds_en   = 1'b1;
                        state_d = ST_RESP;
                    end else begin
                        state_d = miss_nxt;
                    end
                end else begin
                    dw_en   = hit;
                    state_d = ST_THRU;
                end
            end
            ST_EVICT: begin
                if (any_dirty) begin
                    mem_wr_valid = 1'b1;
                    dc_en        = mem_wr_ready;
                end else begin
                    state_d = ST_FREQ;
                end
            end
            ST_FREQ: begin
                mem_rd_req = 1'b1;
                state_d    = ST_FILL;
            end
            ST_FILL: begin
                if (mem_rd_valid) begin
                    dw_en = 1'b1;
                    if (fill_last) begin
                        tv_en   = 1'b1;
                        ds_en   = cpu_we;
                        state_d = ST_RESP;
                    end
                end
            end
            ST_THRU: begin
                mem_wr_valid = 1'b1;
                if (mem_wr_ready) state_d = ST_RESP;
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_INV: begin
                inv_done = 1'b1;
                kill_en  = lk_valid && (lk_tag == inv_tag);
                state_d  = ST_IDLE;
            end
            ST_FLUSH: begin
                if (lk_valid && any_dirty) begin
                    mem_wr_valid = 1'b1;
                    dc_en        = mem_wr_ready;
                end else begin
                    kill_en = 1'b1;
                    if (fl_idx_q == IDX_W'(LINES - 1)) state_d = ST_FDONE;
                end
            end
            ST_FDONE: begin
                flush_done = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Data routed to the store and to memory.
    always_comb begin
        dw_off      = (state_q == ST_FILL) ? fcnt_q : req_off;
        dw_data     = (state_q == ST_FILL && !merge_here) ? mem_rd_data : cpu_wdata;
        mem_rd_addr = {req_tag, req_idx};
        mem_wr_addr = (state_q == ST_THRU) ? cpu_addr : {lk_tag, lk_idx, pick};
        mem_wr_data = (state_q == ST_THRU) ? cpu_wdata : lk_word;
        cpu_rdata   = rdata_q;
    end

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Flush line walker and fill beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_idx_q <= '0;
            fcnt_q   <= '0;
        end else begin
            if (state_q == ST_IDLE)
                fl_idx_q <= '0;
            else if (state_q == ST_FLUSH && !(lk_valid && any_dirty))
                fl_idx_q <= fl_idx_q + 1'b1;
            if (state_q == ST_FREQ)
                fcnt_q <= '0;
            else if (state_q == ST_FILL && mem_rd_valid)
                fcnt_q <= fcnt_q + 1'b1;
        end
    end

    // Load data capture: cached word on a hit, matching beat on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state_q == ST_LOOK && !cpu_we && hit) begin
            rdata_q <= lk_word;
        end else if (state_q == ST_FILL && mem_rd_valid && !cpu_we
                     && fcnt_q == req_off) begin
            rdata_q <= mem_rd_data;
        end
    end

    // ---------------- assertions ----------------
    a_r12_wr_hold: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    a_r3_fill_pulse: assert property (
        @(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    a_r6_clean_before_fill: assert property (
        @(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !(lk_valid && (|lk_dirty)));

    a_r11_one_done: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_ready, inv_done, flush_done}));

    if (!WRITE_BACK) begin : g_wt_chk
        a_r7_never_dirty: assert property (
            @(posedge clk) disable iff (!rst_n)
            lk_dirty == '0);
    end

endmodule

// File: tb/test_wbc_top.sv
// Behavioural memory for the bench: fill after ACC cycles, one beat per
// cycle; each word write is stalled one cycle before acceptance. Keeps a
// log of writes; unwritten words read as 0x5A00_0000 | address.
module mem_model #(
    parameter int ACC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic [13:0] rd_addr,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic        wr_valid,
    input  logic [15:0] wr_addr,
    input  logic [31:0] wr_data,
    output logic        wr_ready
);
    int          rd_cnt, wr_cnt, seq, last_rd_seq, hold_err;
    logic [15:0] wa   [64];
    logic [31:0] wd   [64];
    int          wseq [64];
    logic [13:0] rline;
    logic [3:0]  cnt;
    logic        stall, hold_chk;
    logic [15:0] hold_a;
    logic [31:0] hold_d;
    logic [1:0]  beat;

    function automatic logic [31:0] look(input logic [15:0] a);
        logic [31:0] r;
        r = 32'h5A00_0000 | {16'h0, a};
        for (int i = 0; i < 64; i++)
            if (i < wr_cnt && wa[i] == a) r = wd[i];
        return r;
    endfunction

    always_comb begin
        rd_valid = (cnt != 0) && (cnt <= 4'd4);
        beat     = 2'(4'd4 - cnt);
        rd_data  = look({rline, beat});
        wr_ready = wr_valid && stall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; rd_cnt <= 0; wr_cnt <= 0; seq <= 0; last_rd_seq <= 0;
            stall <= 1'b0; hold_chk <= 1'b0; hold_err <= 0;
            rline <= '0; hold_a <= '0; hold_d <= '0;
        end else begin
            if (rd_req) begin
                rline <= rd_addr; cnt <= 4'(ACC + 4);
                rd_cnt <= rd_cnt + 1; last_rd_seq <= seq; seq <= seq + 1;
            end else if (cnt != 0) begin
                cnt <= cnt - 1'b1;
            end
            if (wr_valid && !stall) stall <= 1'b1;
            if (wr_valid && stall) begin
                wa[wr_cnt[5:0]] <= wr_addr; wd[wr_cnt[5:0]] <= wr_data;
                wseq[wr_cnt[5:0]] <= seq; seq <= seq + 1;
                wr_cnt <= wr_cnt + 1; stall <= 1'b0;
            end
            hold_chk <= wr_valid && !wr_ready;
            hold_a <= wr_addr; hold_d <= wr_data;
            if (hold_chk && (!wr_valid || wr_addr != hold_a || wr_data != hold_d))
                hold_err <= hold_err + 1;
        end
    end
endmodule

// Bench: index 0 is the write-back instance, index 1 the write-through one.
module test_wbc_top;
    localparam int PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [1:0]  creq, cwe, ireq, fq, crdy, idn, fdn, mrq, mrv, mwv, mwr;
    logic [15:0] caddr [2];
    logic [31:0] cwd   [2];
    logic [31:0] crd   [2];
    logic [13:0] iaddr [2];
    logic [13:0] mra   [2];
    logic [31:0] mrd   [2];
    logic [15:0] mwa   [2];
    logic [31:0] mwd   [2];

    int n_chk = 0, n_fail = 0;

    wbc_top #(.WRITE_BACK(1'b1)) i_wbc_top (
        .clk(clk), .rst_n(rst_n), .cpu_req(creq[0]), .cpu_we(cwe[0]),
        .cpu_addr(caddr[0]), .cpu_wdata(cwd[0]), .cpu_ready(crdy[0]),
        .cpu_rdata(crd[0]), .inv_req(ireq[0]), .inv_addr(iaddr[0]),
        .inv_done(idn[0]), .flush_req(fq[0]), .flush_done(fdn[0]),
        .mem_rd_req(mrq[0]), .mem_rd_addr(mra[0]), .mem_rd_valid(mrv[0]),
        .mem_rd_data(mrd[0]), .mem_wr_valid(mwv[0]), .mem_wr_addr(mwa[0]),
        .mem_wr_data(mwd[0]), .mem_wr_ready(mwr[0]));

    wbc_top #(.WRITE_BACK(1'b0)) i_wbc_top_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(creq[1]), .cpu_we(cwe[1]),
        .cpu_addr(caddr[1]), .cpu_wdata(cwd[1]), .cpu_ready(crdy[1]),
        .cpu_rdata(crd[1]), .inv_req(ireq[1]), .inv_addr(iaddr[1]),
        .inv_done(idn[1]), .flush_req(fq[1]), .flush_done(fdn[1]),
        .mem_rd_req(mrq[1]), .mem_rd_addr(mra[1]), .mem_rd_valid(mrv[1]),
        .mem_rd_data(mrd[1]), .mem_wr_valid(mwv[1]), .mem_wr_addr(mwa[1]),
        .mem_wr_data(mwd[1]), .mem_wr_ready(mwr[1]));

    mem_model m_wb (.clk(clk), .rst_n(rst_n), .rd_req(mrq[0]), .rd_addr(mra[0]),
        .rd_valid(mrv[0]), .rd_data(mrd[0]), .wr_valid(mwv[0]), .wr_addr(mwa[0]),
        .wr_data(mwd[0]), .wr_ready(mwr[0]));
    mem_model m_wt (.clk(clk), .rst_n(rst_n), .rd_req(mrq[1]), .rd_addr(mra[1]),
        .rd_valid(mrv[1]), .rd_data(mrd[1]), .wr_valid(mwv[1]), .wr_addr(mwa[1]),
        .wr_data(mwd[1]), .wr_ready(mwr[1]));

    function automatic logic [31:0] base(input logic [15:0] a);
        return 32'h5A00_0000 | {16'h0, a};
    endfunction
    function automatic int rdc(input bit w);
        return w ? m_wt.rd_cnt : m_wb.rd_cnt;
    endfunction
    function automatic int wrc(input bit w);
        return w ? m_wt.wr_cnt : m_wb.wr_cnt;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One processor access; returns data and cycles to cpu_ready.
    task automatic cpu_op(input bit w, input bit we, input logic [15:0] a,
                          input logic [31:0] d, output logic [31:0] q, output int cyc);
        @(negedge clk);
        creq[w] = 1'b1; cwe[w] = we; caddr[w] = a; cwd[w] = d;
        cyc = 0;
        do begin
            @(negedge clk); cyc++;
        end while (!crdy[w] && cyc < 200);
        q = crd[w];
        creq[w] = 1'b0;
        if (cyc >= 200) check(1'b0, "R2", "cpu_ready timeout", 32'(cyc), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] q; int c;
        repeat (3) @(negedge clk);
        check(crdy == 0 && idn == 0 && fdn == 0 && mrq == 0 && mwv == 0, "R1",
              "outputs in reset", {crdy, idn, fdn, mrq, mwv, 22'h0}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        cpu_op(0, 0, 16'h0000, 0, q, c);
        check(rdc(0) == 1, "R1", "first read fills", 32'(rdc(0)), 32'd1);
        check(q == base(16'h0000), "R1", "first read data", q, base(16'h0000));
    endtask

    task automatic t_read();
        logic [31:0] q; int c, r0;
        r0 = rdc(0);
        cpu_op(0, 0, 16'h0003, 0, q, c);
        check(c == 2, "R2", "hit latency", 32'(c), 32'd2);
        check(q == base(16'h0003), "R2", "hit data", q, base(16'h0003));
        check(rdc(0) == r0, "R2", "hit no fill", 32'(rdc(0)), 32'(r0));
        cpu_op(0, 0, 16'h00B6, 0, q, c);
        check(rdc(0) == r0 + 1, "R3", "miss fill count", 32'(rdc(0)), 32'(r0 + 1));
        check(m_wb.rline == 14'h002D, "R3", "fill line addr", 32'(m_wb.rline), 32'h2D);
        check(q == base(16'h00B6), "R3", "miss data", q, base(16'h00B6));
        cpu_op(0, 0, 16'h00B5, 0, q, c);
        check(q == base(16'h00B5) && rdc(0) == r0 + 1, "R3", "line word 1 cached",
              q, base(16'h00B5));
    endtask

    task automatic t_wb_write();
        logic [31:0] q; int c, r0, w0;
        r0 = rdc(0); w0 = wrc(0);
        cpu_op(0, 1, 16'h0041, 32'hD1D1_0001, q, c);
        check(rdc(0) == r0 + 1, "R5", "store miss allocates", 32'(rdc(0)), 32'(r0 + 1));
        check(wrc(0) == w0, "R5", "store miss no mem write", 32'(wrc(0)), 32'(w0));
        cpu_op(0, 1, 16'h0043, 32'hD3D3_0003, q, c);
        check(rdc(0) == r0 + 1 && wrc(0) == w0, "R4", "store hit no traffic",
              32'(wrc(0)), 32'(w0));
        cpu_op(0, 0, 16'h0041, 0, q, c);
        check(q == 32'hD1D1_0001, "R5", "merged word", q, 32'hD1D1_0001);
        cpu_op(0, 0, 16'h0043, 0, q, c);
        check(q == 32'hD3D3_0003, "R4", "store hit readback", q, 32'hD3D3_0003);
        cpu_op(0, 0, 16'h0042, 0, q, c);
        check(q == base(16'h0042), "R5", "unmerged word", q, base(16'h0042));
    endtask

    task automatic t_evict();
        logic [31:0] q; int c, w0;
        w0 = wrc(0);
        cpu_op(0, 0, 16'h0081, 0, q, c);
        check(wrc(0) == w0 + 2, "R6", "only modified words written", 32'(wrc(0)), 32'(w0 + 2));
        check(m_wb.wa[w0] == 16'h0041 && m_wb.wd[w0] == 32'hD1D1_0001, "R6",
              "first write-back", m_wb.wd[w0], 32'hD1D1_0001);
        check(m_wb.wa[w0+1] == 16'h0043 && m_wb.wd[w0+1] == 32'hD3D3_0003, "R6",
              "second write-back", m_wb.wd[w0+1], 32'hD3D3_0003);
        check(m_wb.wseq[w0+1] < m_wb.last_rd_seq, "R6", "write-back before fill",
              32'(m_wb.wseq[w0+1]), 32'(m_wb.last_rd_seq));
        check(q == base(16'h0081), "R6", "new line data", q, base(16'h0081));
        check(m_wb.hold_err == 0, "R12", "write held while stalled", 32'(m_wb.hold_err), 32'd0);
    endtask

    task automatic do_inv(input logic [13:0] la);
        int c = 0;
        @(negedge clk); ireq[0] = 1'b1; iaddr[0] = la;
        do begin @(negedge clk); c++; end while (!idn[0] && c < 50);
        ireq[0] = 1'b0;
    endtask

    task automatic t_inv();
        logic [31:0] q; int c, r0, w0;
        cpu_op(0, 0, 16'h0105, 0, q, c);
        cpu_op(0, 1, 16'h0105, 32'hBAD0_0105, q, c);
        r0 = rdc(0); w0 = wrc(0);
        do_inv(14'h0041);
        cpu_op(0, 0, 16'h0105, 0, q, c);
        check(rdc(0) == r0 + 1, "R9", "refetch after invalidate", 32'(rdc(0)), 32'(r0 + 1));
        check(q == base(16'h0105) && wrc(0) == w0, "R9", "modified word dropped",
              q, base(16'h0105));
        cpu_op(0, 0, 16'h0144, 0, q, c);
        r0 = rdc(0);
        do_inv(14'h0061);
        cpu_op(0, 0, 16'h0144, 0, q, c);
        check(rdc(0) == r0 && q == base(16'h0144), "R9", "other tag kept",
              32'(rdc(0)), 32'(r0));
    endtask

    task automatic t_race();
        logic [31:0] q; int c, r0, ci, cr;
        cpu_op(0, 0, 16'h0208, 0, q, c);
        r0 = rdc(0); ci = 0; cr = 0; c = 0;
        @(negedge clk);
        ireq[0] = 1'b1; iaddr[0] = 14'h0082;
        creq[0] = 1'b1; cwe[0] = 1'b0; caddr[0] = 16'h0208;
        do begin
            @(negedge clk); c++;
            if (idn[0])  begin ci = c; ireq[0] = 1'b0; end
            if (crdy[0]) begin cr = c; q = crd[0]; creq[0] = 1'b0; end
        end while (cr == 0 && c < 100);
        creq[0] = 1'b0; ireq[0] = 1'b0;
        check(ci != 0 && ci < cr, "R11", "invalidate first", 32'(ci), 32'(cr));
        check(rdc(0) == r0 + 1, "R11", "load refetched", 32'(rdc(0)), 32'(r0 + 1));
        check(q == base(16'h0208), "R11", "load data", q, base(16'h0208));
    endtask

    task automatic t_flush();
        logic [31:0] q; int c, w0, r0;
        cpu_op(0, 1, 16'h0302, 32'hF1F1_0302, q, c);
        cpu_op(0, 1, 16'h0307, 32'hF2F2_0307, q, c);
        w0 = wrc(0); c = 0;
        @(negedge clk); fq[0] = 1'b1;
        do begin @(negedge clk); c++; end while (!fdn[0] && c < 500);
        fq[0] = 1'b0;
        check(fdn[0] == 1'b1, "R10", "flush_done seen", 32'(fdn[0]), 32'd1);
        check(wrc(0) == w0 + 2, "R10", "modified words written", 32'(wrc(0)), 32'(w0 + 2));
        r0 = rdc(0);
        cpu_op(0, 0, 16'h0302, 0, q, c);
        check(q == 32'hF1F1_0302 && rdc(0) == r0 + 1, "R10", "line invalid, mem updated",
              q, 32'hF1F1_0302);
        cpu_op(0, 0, 16'h0307, 0, q, c);
        check(q == 32'hF2F2_0307 && rdc(0) == r0 + 2, "R10", "second line", q, 32'hF2F2_0307);
    endtask

    task automatic t_wt();
        logic [31:0] q; int c, r0, w0;
        cpu_op(1, 0, 16'h0010, 0, q, c);
        r0 = rdc(1); w0 = wrc(1);
        cpu_op(1, 1, 16'h0010, 32'h7777_0010, q, c);
        check(wrc(1) == w0 + 1 && m_wt.wa[w0] == 16'h0010 && m_wt.wd[w0] == 32'h7777_0010,
              "R7", "store hit reaches memory", m_wt.wd[w0], 32'h7777_0010);
        cpu_op(1, 0, 16'h0010, 0, q, c);
        check(q == 32'h7777_0010 && rdc(1) == r0, "R7", "store hit updates cache",
              q, 32'h7777_0010);
        cpu_op(1, 0, 16'h0410, 0, q, c);
        check(wrc(1) == w0 + 1, "R7", "eviction writes nothing", 32'(wrc(1)), 32'(w0 + 1));
        r0 = rdc(1);
        cpu_op(1, 1, 16'h0820, 32'h8888_0820, q, c);
        check(wrc(1) == w0 + 2 && rdc(1) == r0, "R8", "store miss goes around",
              32'(rdc(1)), 32'(r0));
        cpu_op(1, 0, 16'h0820, 0, q, c);
        check(rdc(1) == r0 + 1 && q == 32'h8888_0820, "R8", "later read misses",
              q, 32'h8888_0820);
        check(m_wt.hold_err == 0, "R12", "write-through hold", 32'(m_wt.hold_err), 32'd0);
    endtask

    initial begin
        creq = '0; cwe = '0; ireq = '0; fq = '0;
        for (int i = 0; i < 2; i++) begin
            caddr[i] = '0; cwd[i] = '0; iaddr[i] = '0;
        end
        t_reset();
        t_read();
        t_wb_write();
        t_evict();
        t_inv();
        t_race();
        t_flush();
        t_wt();
        summary();
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end
endmodule